// File: doc/BRIEF.md
# Button Auto-Repeat Step Generator

This block turns one held push-button request into step pulses for a downstream level counter. It behaves like keyboard auto-repeat. A free-running binary prescaler divides the input clock and drives a set of divided clock taps. A gated delay counter measures how long a raise or lower request has been held. Once the hold passes a short threshold, the block emits one isolated step. After a longer hold it emits a step on every input clock until the request is dropped.

The request lines are expected to be debounced and synchronous to the clock already. Holding both lines at once counts as no request. The step output says only that a step is due; the direction is taken from the request lines by the downstream counter.

Top module: `repeat_stepper`

## Requirements
- R1: A synchronous active-high reset sets the tap vector, the delay count and the step output to zero. Reset takes priority over every other input.
- R2: The prescaler counts up by one on every clock, modulo 32. Bit i of `taps_o` is the clock divided by 2^(i+1), so bit 4 is the divide-by-32 tap.
- R3: While exactly one request line is high, the delay count goes up by one on each clock edge at which the divide-by-32 tap changes level, in either direction. That is once every 16 clocks. On any other edge the count stays where it is.
- R4: The delay count never passes 13 (0x0D). It holds there for as long as the request stays high.
- R5: When the delay count first reaches 4, `step_o` is high for exactly one clock. It stays low while the count is anywhere from 5 to 12.
- R6: While the delay count is 13, `step_o` is high on every clock.
- R7: One clock edge after the request is released, the delay count is 0 and `step_o` is low.
- R8: When both request lines are high, the block behaves as if neither were high. The delay count goes to 0 and no step is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| req_up_i | input | 1 | Raise request, held while the button is pressed |
| req_dn_i | input | 1 | Lower request, held while the button is pressed |
| taps_o | output | 5 | Divided clock taps: bit i is the clock divided by 2^(i+1) |
| dly_cnt_o | output | 5 | Current delay count, from 0 to 13 |
| step_o | output | 1 | Step pulse for the level counter |

## Verification
The properties assume the request lines are already clean, synchronous levels that are sampled only at the rising edge. They also assume the lines never carry unknown values after reset, so that the XOR of the two lines is always a defined request. The bench drives both lines only at a quarter period after the rising edge. It changes them only right after a reset or at a vector boundary, so every hold starts from a known prescaler phase. That makes the pulse positions exact functions of the hold length.

// File: rtl/rstep_pkg.sv
package rstep_pkg;
    localparam int PRE_W     = 5;
    localparam int DLY_W     = 5;
    localparam int FIRST_CNT = 4;
    localparam int SAT_CNT   = 13;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             step;
    } dly_state_t;
endpackage

// File: rtl/rstep_prescaler.sv
module rstep_prescaler
    import rstep_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] taps_o,
    output logic         tick_o
);
    localparam logic [W-2:0] LOW_ALL = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // tap i toggles every 2^i clocks, i.e. divide by 2^(i+1)
    for (genvar i = 0; i < W; i++) begin : g_tap
        assign taps_o[i] = cnt_q[i];
    end

    // the top tap changes level on the edge where all lower bits wrap
    assign tick_o = (cnt_q[W-2:0] == LOW_ALL);
endmodule

// File: rtl/rstep_req.sv
module rstep_req (
    input  logic up_i,
    input  logic dn_i,
    output logic active_o
);
    // both pressed is treated like none pressed
    assign active_o = up_i ^ dn_i;
endmodule

// File: rtl/rstep_delay.sv
module rstep_delay
    import rstep_pkg::*;
#(
    parameter int W     = DLY_W,
    parameter int FIRST = FIRST_CNT,
    parameter int SAT   = SAT_CNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active_i,
    input  logic         tick_i,
    output logic [W-1:0] dly_o,
    output logic         step_o
);
    localparam logic [W-1:0] SAT_V    = W'(SAT);
    localparam logic [W-1:0] PRE_FIRST = W'(FIRST - 1);

    typedef struct packed {
        logic [W-1:0] dly;
        logic         step;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d.dly = '0;
        end else if (tick_i && (st_q.dly != SAT_V)) begin
            st_d.dly = st_q.dly + 1'b1;
        end
        st_d.step = active_i &&
                    ((tick_i && (st_q.dly == PRE_FIRST)) || (st_d.dly == SAT_V));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dly_o  = st_q.dly;
    assign step_o = st_q.step;
endmodule

// File: rtl/repeat_stepper.sv
module repeat_stepper
    import rstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_up_i,
    input  logic             req_dn_i,
    output logic [PRE_W-1:0] taps_o,
    output logic [DLY_W-1:0] dly_cnt_o,
    output logic             step_o
);
    logic tick;
    logic active;

    rstep_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .taps_o (taps_o),
        .tick_o (tick)
    );

    rstep_req u_req (
        .up_i     (req_up_i),
        .dn_i     (req_dn_i),
        .active_o (active)
    );

    rstep_delay #(.W(DLY_W), .FIRST(FIRST_CNT), .SAT(SAT_CNT)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .tick_i   (tick),
        .dly_o    (dly_cnt_o),
        .step_o   (step_o)
    );
endmodule

// File: rtl/repeat_stepper_chk.sv
module repeat_stepper_chk
    import rstep_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_up_i,
    input logic             req_dn_i,
    input logic [PRE_W-1:0] taps_o,
    input logic [DLY_W-1:0] dly_cnt_o,
    input logic             step_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (taps_o == '0 && dly_cnt_o == '0 && !step_o)); // R1
    AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> taps_o == $past(taps_o) + 1'b1); // R2
    AST_DLY_HOLD: assert property (@(posedge clk) disable iff (rst) ((req_up_i ^ req_dn_i) && taps_o[3:0] != 4'hF) |=> $stable(dly_cnt_o)); // R3
    AST_DLY_CAP: assert property (@(posedge clk) disable iff (rst) dly_cnt_o <= DLY_W'(SAT_CNT)); // R4
    AST_PULSE_WHERE: assert property (@(posedge clk) disable iff (rst) step_o |-> (dly_cnt_o == DLY_W'(FIRST_CNT) || dly_cnt_o == DLY_W'(SAT_CNT))); // R5
    AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (rst) (step_o && dly_cnt_o == DLY_W'(FIRST_CNT)) |=> !step_o); // R5
    AST_SAT_REPEAT: assert property (@(posedge clk) disable iff (rst) (dly_cnt_o == DLY_W'(SAT_CNT)) |-> step_o); // R6
    AST_RELEASE_STOP: assert property (@(posedge clk) disable iff (rst) (!req_up_i && !req_dn_i) |=> (dly_cnt_o == '0 && !step_o)); // R7
    AST_BOTH_IDLE: assert property (@(posedge clk) disable iff (rst) (req_up_i && req_dn_i) |=> (dly_cnt_o == '0 && !step_o)); // R8
endmodule

bind repeat_stepper repeat_stepper_chk u_chk (.*);

// File: tb/repeat_stepper_bench.sv
module repeat_stepper_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up  = 1'b0;
    logic       dn  = 1'b0;
    logic [4:0] taps;
    logic [4:0] dly;
    logic       step;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    repeat_stepper u_repeat_stepper (
        .clk       (clk),
        .rst       (rst),
        .req_up_i  (up),
        .req_dn_i  (dn),
        .taps_o    (taps),
        .dly_cnt_o (dly),
        .step_o    (step)
    );

    // vector table: up, dn, hold edges, expected final count, expected pulses
    localparam int NV = 8;
    localparam int V_UP [NV] = '{1, 0, 1, 1, 0, 0, 1, 0};
    localparam int V_DN [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
    localparam int V_N  [NV] = '{30, 64, 100, 300, 50, 208, 250, 210};
    localparam int V_DLY[NV] = '{1, 4, 6, 0, 0, 13, 13, 13};
    localparam int V_PLS[NV] = '{0, 1, 1, 0, 0, 2, 44, 4};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        rst = 1'b1; up = 1'b0; dn = 1'b0;
        tick();
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk(taps == 0, "R1 taps after reset", taps, 0);
        chk(dly == 0, "R1 count after reset", dly, 0);
        chk(step == 0, "R1 step after reset", step, 0);

        // R2: prescaler free running modulo 32
        for (int k = 1; k <= 40; k++) begin
            tick();
            chk(taps == (k % 32), "R2 prescaler", taps, k % 32);
        end

        // table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            int pulses;
            pulses = 0;
            do_reset();
            up = V_UP[v][0];
            dn = V_DN[v][0];
            for (int k = 1; k <= V_N[v]; k++) begin
                tick();
                if (step) pulses++;
            end
            chk(dly == V_DLY[v], "R3/R4/R8 final count", dly, V_DLY[v]);
            chk(pulses == V_PLS[v], "R5/R6/R8 pulse count", pulses, V_PLS[v]);
            up = 1'b0; dn = 1'b0;
            tick();
            chk(dly == 0 && step == 0, "R7 release clears", {dly, step}, 0);
        end

        // R5 R6 R3: per-edge pulse and count profile of one long hold
        do_reset();
        up = 1'b1;
        for (int k = 1; k <= 215; k++) begin
            int edly;
            bit estep;
            tick();
            edly  = (k / 16 > 13) ? 13 : k / 16;
            estep = (k == 64) || (k >= 208);
            chk(dly == edly, "R3 count per edge", dly, edly);
            chk(step == estep, "R5_R6 step per edge", step, estep);
        end

        // R1: reset while the request is still held
        rst = 1'b1;
        tick();
        chk(dly == 0 && step == 0 && taps == 0, "R1 reset during hold", {taps, dly, step}, 0);
        rst = 1'b0;
        up = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule